// File: doc/BRIEF.md
# Cascaded Programmable Duty-Cycle Clock Divider

This block divides a fast input clock through a chain of divider stages in series (two by default). Every stage counts the periods of the signal that feeds it and produces an output whose high time and low time are programmed independently. Each length is written as a count-minus-one field, so a field of 0x7 gives eight input periods. The first stage counts fast-clock cycles. Each later stage counts the output periods of the stage in front of it, so the phase lengths of the final stage are multiples of the period of the stage before it.

Each stage can be bypassed. A bypassed stage stops counting and hands its input straight to its output. Each stage also has a start-level select that sets the level it holds while a synchronisation request is applied. All stages obey a chip-level sync pulse. A channel-wide ignore-sync control lets the channel disregard that pulse. A force-high control pins the output at 1, but only while ignore-sync is also set.

The configuration arrives on parallel ports and is expected to stay static. Any change to a phase length is applied only when the next phase of that length begins.

Top module: `cdiv_channel`

## Requirements
- R1: When a stage divides, each low phase of its output lasts (low field + 1) periods of that stage's input.
- R2: When a stage divides, each high phase of its output lasts (high field + 1) periods of that stage's input.
- R3: While `sync_i` is 1 and `nosync_i` is 0, every stage holds its output at its start level. After `sync_i` returns to 0 the output starts from that level.
- R4: A start-level bit of 1 makes a stage begin in its high phase after sync. A bit of 0 makes it begin in its low phase. Bit k of `start_hi_i` belongs to stage k.
- R5: A stage whose bypass bit is 1 passes its input through unchanged. Bit k of `bypass_i` belongs to stage k. With every stage bypassed, `div_clk_o` follows `clk_i`.
- R6: Stage k+1 counts output periods of stage k. With stage 0 dividing, the final high phase therefore lasts (H1+1)*((H0+1)+(L0+1)) fast cycles, and the final low phase is built the same way. Stage k's fields sit at bits [4k+3:4k] of `lo_cyc_i` and `hi_cyc_i`.
- R7: With `nosync_i` set to 1, a pulse on `sync_i` does not change the phase lengths or the output.
- R8: With `force_hi_i` and `nosync_i` both at 1, `div_clk_o` is constantly 1. `force_hi_i` with `nosync_i` at 0 has no effect.
- R9: `run_o` is 0 while an obeyed sync is applied or the output is forced. Otherwise it is 1.
- R10: A change to a length field while a phase is running does not alter that phase. The new length applies from the next phase of that kind.
- R11: During reset the output sits at the start level of the last dividing stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Chip-level synchronisation request |
| nosync_i | input | 1 | Ignore `sync_i` when 1 |
| force_hi_i | input | 1 | Force output high (needs `nosync_i`) |
| lo_cyc_i | input | NUM_STAGES*CNT_W | Low-phase lengths minus one, per stage |
| hi_cyc_i | input | NUM_STAGES*CNT_W | High-phase lengths minus one, per stage |
| start_hi_i | input | NUM_STAGES | Start level per stage |
| bypass_i | input | NUM_STAGES | Bypass per stage |
| div_clk_o | output | 1 | Divided clock |
| run_o | output | 1 | Divider output is live |

## Verification
Two events can land in the same cycle. The first is a phase boundary together with a field rewrite. The bench rewrites the high length in the cycle where a high phase has just begun. It then checks that this phase keeps its old length and that the following high phase takes the new one. The second is a sync pulse together with a phase in progress while sync is ignored. The bench raises `sync_i` inside a high phase with `nosync_i` set and expects that phase to keep its full width with `run_o` still 1. Randomized lengths, start levels and bypass settings are judged against widths computed from the cascade formula.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   function automatic phase_e ph_flip(input phase_e p);
      return (p == PH_HIGH) ? PH_LOW : PH_HIGH;
   endfunction

   function automatic phase_e ph_from_bit(input logic b);
      return b ? PH_HIGH : PH_LOW;
   endfunction

endpackage

// File: rtl/cdiv_stage.sv
module cdiv_stage
   import cdiv_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             hold_i,
   input  logic             en_i,
   input  logic             lvl_i,
   input  logic [CNT_W-1:0] lo_i,
   input  logic [CNT_W-1:0] hi_i,
   input  logic             start_hi_i,
   input  logic             bypass_i,
   output logic             lvl_o,
   output logic             tick_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_width
      $error("cdiv_stage: CNT_W must be at least 1");
   end

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic             step;
   logic             at_end;

   assign step   = en_i & ~bypass_i & ~hold_i;
   assign at_end = (cnt_q == len_q);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i || hold_i) begin
         phase_q <= ph_from_bit(start_hi_i);
         cnt_q   <= '0;
         len_q   <= start_hi_i ? hi_i : lo_i;
      end else if (step) begin
         if (at_end) begin
            phase_q <= ph_flip(phase_q);
            cnt_q   <= '0;
            len_q   <= (phase_q == PH_HIGH) ? lo_i : hi_i;
         end else begin
            cnt_q   <= cnt_q + CNT_ONE;
         end
      end
   end

   assign lvl_o  = bypass_i ? lvl_i : (phase_q == PH_HIGH);
   assign tick_o = bypass_i ? en_i : (step & at_end & (phase_q == PH_LOW));

   p_sync_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      hold_i |=> (cnt_q == '0) && (phase_q == ph_from_bit($past(start_hi_i))));

   p_cnt_in_phase_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cnt_q <= len_q);

   p_no_edge_without_input_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!en_i && !hold_i) |=> $stable(phase_q) && $stable(cnt_q));

   p_len_only_at_boundary_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!hold_i && !(step && at_end)) |=> $stable(len_q));

endmodule

// File: rtl/cdiv_out_mux.sv
module cdiv_out_mux (
   input  logic clk_i,
   input  logic lvl_i,
   input  logic all_byp_i,
   input  logic force_eff_i,
   input  logic hold_i,
   output logic div_clk_o,
   output logic run_o
);

   always_comb begin
      if (force_eff_i)    div_clk_o = 1'b1;
      else if (all_byp_i) div_clk_o = clk_i;
      else                div_clk_o = lvl_i;
   end

   assign run_o = ~hold_i & ~force_eff_i;

endmodule

// File: rtl/cdiv_channel.sv
module cdiv_channel #(
   parameter int unsigned NUM_STAGES = 2,
   parameter int unsigned CNT_W      = 4
) (
   input  logic                        clk_i,
   input  logic                        rst_n_i,
   input  logic                        sync_i,
   input  logic                        nosync_i,
   input  logic                        force_hi_i,
   input  logic [NUM_STAGES*CNT_W-1:0] lo_cyc_i,
   input  logic [NUM_STAGES*CNT_W-1:0] hi_cyc_i,
   input  logic [NUM_STAGES-1:0]       start_hi_i,
   input  logic [NUM_STAGES-1:0]       bypass_i,
   output logic                        div_clk_o,
   output logic                        run_o
);

   localparam int unsigned LAST = NUM_STAGES - 1;

   if (NUM_STAGES < 1) begin : g_bad_stages
      $error("cdiv_channel: NUM_STAGES must be at least 1");
   end

   logic hold;
   logic force_eff;
   logic all_byp;
   logic [NUM_STAGES-1:0] tick_w;
   logic [NUM_STAGES-1:0] lvl_w;

   assign hold      = sync_i & ~nosync_i;
   assign force_eff = force_hi_i & nosync_i;
   assign all_byp   = &bypass_i;

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      logic en_in;
      logic lvl_in;
      if (k == 0) begin : g_head
         assign en_in  = 1'b1;
         assign lvl_in = 1'b0;
      end else begin : g_tail
         assign en_in  = tick_w[k-1];
         assign lvl_in = lvl_w[k-1];
      end

      cdiv_stage #(.CNT_W(CNT_W)) u_stage (
         .clk_i      (clk_i),
         .rst_n_i    (rst_n_i),
         .hold_i     (hold),
         .en_i       (en_in),
         .lvl_i      (lvl_in),
         .lo_i       (lo_cyc_i[k*CNT_W +: CNT_W]),
         .hi_i       (hi_cyc_i[k*CNT_W +: CNT_W]),
         .start_hi_i (start_hi_i[k]),
         .bypass_i   (bypass_i[k]),
         .lvl_o      (lvl_w[k]),
         .tick_o     (tick_w[k])
      );
   end

   cdiv_out_mux u_mux (
      .clk_i       (clk_i),
      .lvl_i       (lvl_w[LAST]),
      .all_byp_i   (all_byp),
      .force_eff_i (force_eff),
      .hold_i      (hold),
      .div_clk_o   (div_clk_o),
      .run_o       (run_o)
   );

   p_force_pins_high_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (force_hi_i && nosync_i) |-> div_clk_o);

   p_run_low_in_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (sync_i && !nosync_i) |-> !run_o);

   p_ignored_sync_runs_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (nosync_i && !force_hi_i) |-> run_o);

endmodule

// File: tb/cdiv_channel_test.sv
module cdiv_channel_test;

   localparam int NS = 2;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n, sync_s, nosync_s, force_s;
   logic [CW-1:0] lo_c [NS];
   logic [CW-1:0] hi_c [NS];
   logic [NS-1:0] start_s, byp_s;
   logic div_clk, run;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cdiv_channel #(.NUM_STAGES(NS), .CNT_W(CW)) uut (
      .clk_i(clk), .rst_n_i(rst_n), .sync_i(sync_s), .nosync_i(nosync_s),
      .force_hi_i(force_s), .lo_cyc_i({lo_c[1], lo_c[0]}), .hi_cyc_i({hi_c[1], hi_c[0]}),
      .start_hi_i(start_s), .bypass_i(byp_s), .div_clk_o(div_clk), .run_o(run)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int period0(input int h0, input int l0, input bit b0);
      return b0 ? 1 : (h0 + 1) + (l0 + 1);
   endfunction

   function automatic int exp_width(input bit lvl);
      int p;
      p = period0(hi_c[0], lo_c[0], byp_s[0]);
      if (byp_s[1]) return lvl ? (hi_c[0] + 1) : (lo_c[0] + 1);
      return lvl ? (hi_c[1] + 1) * p : (lo_c[1] + 1) * p;
   endfunction

   task automatic measure(output logic first, output int r2len, output logic r2lvl,
                          output int r3len);
      logic cur;
      int run_len, idx;
      sync_s = 1'b1;
      repeat (3) @(negedge clk);
      first = div_clk;
      chk(run == 1'b0, "R9", run, 0);
      sync_s = 1'b0;
      cur = first; run_len = 0; idx = 1; r2len = 0; r3len = 0; r2lvl = ~first;
      for (int i = 0; i < 4000 && idx < 4; i++) begin
         @(negedge clk);
         if (div_clk !== cur) begin
            if (idx == 2) r2len = run_len;
            if (idx == 3) r3len = run_len;
            idx++;
            cur = div_clk;
            run_len = 1;
            if (idx == 2) r2lvl = cur;
         end else run_len++;
      end
   endtask

   task automatic trial(input string tag);
      logic first, r2lvl;
      int r2, r3;
      bit exp_first;
      if (&byp_s) begin
         @(posedge clk); #5;
         chk(div_clk == 1'b1, "R5 clk high", div_clk, 1);
         @(negedge clk); #5;
         chk(div_clk == 1'b0, "R5 clk low", div_clk, 0);
         return;
      end
      exp_first = byp_s[1] ? start_s[0] : start_s[1];
      measure(first, r2, r2lvl, r3);
      chk(first == exp_first, {tag, " R3 R4 start level"}, first, exp_first);
      chk(run == 1'b1, {tag, " R9 running"}, run, 1);
      chk(r2 == exp_width(r2lvl), {tag, r2lvl ? " R2 R6 high" : " R1 R6 low"}, r2, exp_width(r2lvl));
      chk(r3 == exp_width(~r2lvl), {tag, r2lvl ? " R1 R6 low" : " R2 R6 high"}, r3, exp_width(~r2lvl));
   endtask

   task automatic wait_level(input logic lvl);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (div_clk == lvl) break;
      end
   endtask

   task automatic count_run(input logic lvl, output int n);
      n = 0;
      for (int i = 0; i < 2000; i++) begin
         if (div_clk != lvl) break;
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd2024));
      rst_n = 1'b0; sync_s = 1'b0; nosync_s = 1'b0; force_s = 1'b0;
      lo_c[0] = 4'h1; hi_c[0] = 4'h1; lo_c[1] = 4'h1; hi_c[1] = 4'h1;
      start_s = 2'b10; byp_s = 2'b00;
      repeat (3) @(negedge clk);
      chk(div_clk == 1'b1, "R11 reset level", div_clk, 1);
      rst_n = 1'b1;

      // directed cascade corner cases
      trial("default");
      lo_c[0] = 4'h0; hi_c[0] = 4'h0; lo_c[1] = 4'hF; hi_c[1] = 4'hF; start_s = 2'b00;
      trial("max stage1");
      byp_s = 2'b01; lo_c[1] = 4'h0; hi_c[1] = 4'h0; start_s = 2'b10;
      trial("stage0 bypass");
      byp_s = 2'b10; hi_c[0] = 4'hF; lo_c[0] = 4'h0; start_s = 2'b01;
      trial("stage1 bypass");
      byp_s = 2'b11;
      trial("all bypass");

      // randomized configurations
      for (int t = 0; t < 16; t++) begin
         lo_c[0] = 4'($urandom % 8); hi_c[0] = 4'($urandom % 8);
         lo_c[1] = 4'($urandom % 8); hi_c[1] = 4'($urandom % 8);
         start_s = 2'($urandom % 4);
         byp_s = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'b00;
         trial("random");
      end

      // R8: force without nosync has no effect
      byp_s = 2'b10; lo_c[0] = 4'h2; hi_c[0] = 4'h4; start_s = 2'b00; force_s = 1'b1;
      trial("R8 force ignored");
      // R8: force with nosync pins output high
      nosync_s = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(div_clk == 1'b1, "R8 forced high", div_clk, 1);
      end
      chk(run == 1'b0, "R9 forced not running", run, 0);
      force_s = 1'b0;

      // R7: sync ignored while nosync is set
      lo_c[0] = 4'h3; hi_c[0] = 4'h3;
      wait_level(1'b0);
      wait_level(1'b1);
      @(negedge clk);
      sync_s = 1'b1;
      @(negedge clk);
      chk(run == 1'b1, "R7 R9 still running", run, 1);
      sync_s = 1'b0;
      count_run(1'b1, n);
      chk(n + 2 == 4, "R7 high width across sync", n + 2, 4);
      nosync_s = 1'b0;

      // R10: field change at the start of a phase
      lo_c[0] = 4'h7; hi_c[0] = 4'h7; start_s = 2'b00;
      sync_s = 1'b1;
      repeat (2) @(negedge clk);
      sync_s = 1'b0;
      wait_level(1'b1);
      hi_c[0] = 4'h1;
      count_run(1'b1, n);
      chk(n == 8, "R10 running phase kept", n, 8);
      count_run(1'b0, n);
      chk(n == 8, "R10 low phase", n, 8);
      count_run(1'b1, n);
      chk(n == 2, "R10 new high length", n, 2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule